// File: doc/BRIEF.md
# SPI Slave Command Decoder

This block is the command front end of an SPI slave. It works on whole bytes: a shift stage outside the block presents each received byte with a one-cycle strobe. At that same strobe the shift stage takes the byte that the block drives on `tx_byte` and shifts it out. The decoder recognises the opcode in the first byte of a frame and works out from it how many field bytes follow. It gathers those bytes into an address, a size or a data word. When the CRC7 option is on, it checks one trailing check byte. It then runs at most one access on a simple register port toward internal logic.

The reply starts in the byte slot right after the last command byte. It is the opcode echoed back, then a status byte. For the two single-word read commands, the reply goes on with a fixed number of 0x00 filler bytes, a data-start tag and four data bytes. When the CRC16 option is on and the access is not clockless, two check bytes follow the data. While the chip select is high the decoder is held idle. The host raises it between commands, or raises it early to drop a frame it has only partly sent.

The assumptions are as follows. Byte strobes come at least two clock cycles apart. Internal logic presents `reg_rdata` in the cycle after a `reg_rd` pulse. The CRC options do not change during a frame. The number of filler bytes is the parameter `FILL_BYTES`, with a range of 0 to 4.

Top module: `spi_cmd_decoder`

## Requirements
- R1: The number of field bytes after the opcode depends on the opcode: 0xCA single read 3, 0xC4 internal read 3, 0xC9 single write 7, 0xC3 internal write 6, 0xC1/0xC2 5, 0xC7/0xC8 6, and 3 for every other value. When `crc7_en` is high, one check byte follows the fields. The reply begins in the very next byte slot.
- R2: Single read (0xCA) takes a 24-bit address, most significant byte first. It gives one `reg_rd` pulse with `reg_internal`=0 and `reg_clockless`=0.
- R3: Internal read (0xC4) takes two address bytes and then one ignored byte. `reg_addr` = {9'b0, first[6:0], second}, and `reg_clockless` = bit 7 of the first byte. It gives one `reg_rd` pulse with `reg_internal`=1.
- R4: Single write (0xC9) takes a 24-bit address and then a 32-bit word, both most significant byte first. It gives one `reg_wr` pulse that carries them.
- R5: Internal write (0xC3) takes two address bytes, decoded as in R3, and then a 32-bit word sent most significant byte first. It gives one `reg_wr` pulse with `reg_internal`=1.
- R6: The first reply byte is the received opcode. The second is the status: 0x00 for success.
- R7: After a successful read, the status byte is followed by `FILL_BYTES` bytes of 0x00, then the tag 0xF3, then the read word least significant byte first.
- R8: When `crc16_en` is high and the read is not clockless, two more bytes follow the data. They hold a CRC-16 (polynomial 0x1021, seed 0xFFFF, MSB-first) over the four data bytes in the order they were sent, high byte first. A clockless read never appends them.
- R9: The CRC7 check byte is {crc[6:0], 1'b0}. The CRC uses polynomial x^7+x^3+1, seed 0x7F, MSB-first, and covers the opcode and all field bytes. On a mismatch the status is 0x02, there is no register access and there is no data phase.
- R10: An opcode outside the list in R1 gives status 0x01 and no register access. This status wins over a CRC7 mismatch.
- R11: The DMA, extended DMA, terminate, repeat and reset opcodes (0xC1, 0xC2, 0xC5–0xC8, 0xCF) reply with status 0x00 and cause no register access.
- R12: A high `cs_n` drops any partly received frame or reply at once, with no register access. The next frame after `cs_n` falls decodes normally.
- R13: `tx_byte` is 0x00 while the decoder is idle or receiving. After the last reply byte, the next strobe is taken as a new opcode.
- R14: Each frame makes at most one single-cycle access, and `reg_rd` and `reg_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high forces idle |
| rx_valid | input | 1 | One-cycle strobe: a byte slot has completed |
| rx_byte | input | 8 | Byte received in that slot |
| tx_byte | output | 8 | Byte to be shifted out in the next slot |
| crc7_en | input | 1 | Expect and check a CRC7 byte on commands |
| crc16_en | input | 1 | Append CRC16 to non-clockless read data |
| reg_rd | output | 1 | Register read pulse |
| reg_wr | output | 1 | Register write pulse |
| reg_addr | output | 24 | Register address |
| reg_internal | output | 1 | Access targets the internal register space |
| reg_clockless | output | 1 | Internal access flagged as clockless |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
The bench sends random mixes of the four access commands with random CRC settings, back to back on one chip select. It checks that the reply lands in exactly the slot after the frame. A decoder that counted one field byte too many or too few would shift the echo and status by a slot, and it would also read a CRC byte as data. Two cases target the rule that a bad check byte or an unknown opcode must stop the access: a corrupted CRC7 byte, and an unknown opcode that carries a correct CRC7. A decoder that checked too late would still pulse the register port. Three more cases cover the rest. A frame dropped halfway by chip select must leave no write behind. Clockless reads must never grow CRC16 bytes. The filler, tag and little-endian data bytes must sit at their fixed offsets so that the host's tag search finds them.

// File: rtl/spi_cmd_pkg.sv
// Shared definitions for the SPI command decoder: opcode values, status
// codes, access kinds, the per-opcode field count and bytewise CRC steps.
package spi_cmd_pkg;

    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 32;
    localparam int MAX_FIELDS = 7;
    localparam int FLD_W      = MAX_FIELDS * 8;

    localparam logic [7:0] OP_DMA_WR  = 8'hC1;
    localparam logic [7:0] OP_DMA_RD  = 8'hC2;
    localparam logic [7:0] OP_INT_WR  = 8'hC3;
    localparam logic [7:0] OP_INT_RD  = 8'hC4;
    localparam logic [7:0] OP_TERM    = 8'hC5;
    localparam logic [7:0] OP_REPEAT  = 8'hC6;
    localparam logic [7:0] OP_XDMA_WR = 8'hC7;
    localparam logic [7:0] OP_XDMA_RD = 8'hC8;
    localparam logic [7:0] OP_SGL_WR  = 8'hC9;
    localparam logic [7:0] OP_SGL_RD  = 8'hCA;
    localparam logic [7:0] OP_RESET   = 8'hCF;

    localparam logic [7:0] ST_OK      = 8'h00;
    localparam logic [7:0] ST_BAD_OP  = 8'h01;
    localparam logic [7:0] ST_BAD_CRC = 8'h02;
    localparam logic [7:0] DATA_TAG   = 8'hF3;

    typedef enum logic [1:0] {ACC_NONE, ACC_READ, ACC_WRITE} acc_e;

    // Field bytes that follow a given opcode (unknown opcodes take three).
    function automatic logic [2:0] field_count(input logic [7:0] op);
        case (op)
            OP_DMA_WR, OP_DMA_RD:   return 3'd5;
            OP_XDMA_WR, OP_XDMA_RD: return 3'd6;
            OP_INT_WR:              return 3'd6;
            OP_SGL_WR:              return 3'd7;
            default:                return 3'd3;
        endcase
    endfunction

    // True for every opcode the decoder recognises.
    function automatic logic known_op(input logic [7:0] op);
        case (op)
            OP_DMA_WR, OP_DMA_RD, OP_INT_WR, OP_INT_RD, OP_TERM, OP_REPEAT,
            OP_XDMA_WR, OP_XDMA_RD, OP_SGL_WR, OP_SGL_RD, OP_RESET: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // One byte through CRC7 x^7+x^3+1, most significant bit first.
    function automatic logic [6:0] crc7_byte(input logic [6:0] seed, input logic [7:0] b);
        logic [6:0] c;
        logic       fb;
        c = seed;
        for (int i = 7; i >= 0; i--) begin
            fb = c[6] ^ b[i];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // One byte through CRC-16 polynomial 0x1021, most significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] seed, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = seed;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_cmd_crc7.sv
// Running CRC7 over the command bytes of one frame.
// Assumes: restart is asserted with the opcode byte so the seed is reloaded.
module spi_cmd_crc7
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       restart,
    input  logic [7:0] din,
    output logic [6:0] crc
);

    // Fold each accepted byte into the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= 7'h7F;
        else if (upd)
            crc <= crc7_byte(restart ? 7'h7F : crc, din);
    end

endmodule

// File: rtl/spi_cmd_frame.sv
// Frame collector: takes the opcode, gathers its field bytes, checks the
// optional CRC7 byte, and decodes the register access.
// Assumes: crc7_en is static during a frame; the responder signals resp_last
// on the strobe of its final reply byte.
module spi_cmd_frame
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              crc7_en,
    input  logic              resp_last,
    output logic              frm_done,
    output logic [7:0]        frm_op,
    output logic [7:0]        frm_status,
    output acc_e              frm_acc,
    output logic [ADDR_W-1:0] frm_addr,
    output logic              frm_internal,
    output logic              frm_clockless,
    output logic [DATA_W-1:0] frm_wdata
);

    typedef enum logic [1:0] {F_OP, F_FIELD, F_WAIT} fstate_e;

    fstate_e           state;
    logic [7:0]        op_q;
    logic [2:0]        need_q;
    logic [2:0]        cnt_q;
    logic [FLD_W-1:0]  fld_q;
    logic [FLD_W-1:0]  fld_now;
    logic [6:0]        crc_q;
    logic              strobe, in_field, crc_byte, finish, crc_good;
    acc_e              dec_acc;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_int, dec_clk;
    logic [DATA_W-1:0] dec_data;
    logic [7:0]        dec_status;

    assign strobe   = rx_valid && !cs_n;
    assign in_field = (state == F_FIELD) && (cnt_q < need_q);
    assign crc_byte = (state == F_FIELD) && (cnt_q == need_q);
    assign finish   = strobe && ((in_field && cnt_q == need_q - 3'd1 && !crc7_en) || crc_byte);
    assign crc_good = !crc_byte || (rx_byte == {crc_q, 1'b0});
    assign fld_now  = in_field ? {fld_q[FLD_W-9:0], rx_byte} : fld_q;

    spi_cmd_crc7 u_crc7 (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (strobe && (state == F_OP || in_field)),
        .restart (state == F_OP),
        .din     (rx_byte),
        .crc     (crc_q)
    );

    // Decode the access from the opcode and the fields including this byte.
    always_comb begin
        dec_acc  = ACC_NONE;
        dec_addr = '0;
        dec_int  = 1'b0;
        dec_clk  = 1'b0;
        dec_data = '0;
        case (op_q)
            OP_SGL_RD: begin
                dec_acc  = ACC_READ;
                dec_addr = fld_now[23:0];
            end
            OP_INT_RD: begin
                dec_acc  = ACC_READ;
                dec_int  = 1'b1;
                dec_clk  = fld_now[23];
                dec_addr = {9'd0, fld_now[22:16], fld_now[15:8]};
            end
            OP_SGL_WR: begin
                dec_acc  = ACC_WRITE;
                dec_addr = fld_now[55:32];
                dec_data = fld_now[31:0];
            end
            OP_INT_WR: begin
                dec_acc  = ACC_WRITE;
                dec_int  = 1'b1;
                dec_clk  = fld_now[47];
                dec_addr = {9'd0, fld_now[46:40], fld_now[39:32]};
                dec_data = fld_now[31:0];
            end
            default: ;
        endcase
        if (!known_op(op_q))
            dec_status = ST_BAD_OP;
        else if (!crc_good)
            dec_status = ST_BAD_CRC;
        else
            dec_status = ST_OK;
        if (dec_status != ST_OK)
            dec_acc = ACC_NONE;
    end

    // Frame sequencing: opcode, fields, optional check byte, wait for reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= F_OP;
            op_q          <= '0;
            need_q        <= '0;
            cnt_q         <= '0;
            fld_q         <= '0;
            frm_done      <= 1'b0;
            frm_op        <= '0;
            frm_status    <= '0;
            frm_acc       <= ACC_NONE;
            frm_addr      <= '0;
            frm_internal  <= 1'b0;
            frm_clockless <= 1'b0;
            frm_wdata     <= '0;
        end else if (cs_n) begin
            state    <= F_OP;
            frm_done <= 1'b0;
        end else begin
            frm_done <= 1'b0;
            case (state)
                F_OP: if (rx_valid) begin
                    op_q   <= rx_byte;
                    need_q <= field_count(rx_byte);
                    cnt_q  <= '0;
                    fld_q  <= '0;
                    state  <= F_FIELD;
                end
                F_FIELD: if (rx_valid) begin
                    if (in_field) begin
                        fld_q <= fld_now;
                        cnt_q <= cnt_q + 3'd1;
                    end
                    if (finish) begin
                        frm_done      <= 1'b1;
                        frm_op        <= op_q;
                        frm_status    <= dec_status;
                        frm_acc       <= dec_acc;
                        frm_addr      <= dec_addr;
                        frm_internal  <= dec_int;
                        frm_clockless <= dec_clk;
                        frm_wdata     <= dec_data;
                        state         <= F_WAIT;
                    end
                end
                F_WAIT: if (resp_last) state <= F_OP;
                default: state <= F_OP;
            endcase
        end
    end

    p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !known_op(frm_op)) |-> (frm_status == ST_BAD_OP));

    p_err_no_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_status != ST_OK) |-> (frm_acc == ACC_NONE));

endmodule

// File: rtl/spi_cmd_resp.sv
// Reply sequencer: echoes the opcode and status, issues the register
// access, and for reads emits filler, tag, data and optional CRC16.
// Assumes: reg_rdata is valid the cycle after reg_rd; byte strobes are at
// least two cycles apart; FILL_BYTES is between 0 and 4.
module spi_cmd_resp
    import spi_cmd_pkg::*;
#(
    parameter int FILL_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic              crc16_en,
    input  logic              frm_done,
    input  logic [7:0]        frm_op,
    input  logic [7:0]        frm_status,
    input  acc_e              frm_acc,
    input  logic              frm_clockless,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic              resp_last,
    output logic [7:0]        tx_byte
);

    localparam int TAG_SLOT  = 2 + FILL_BYTES;
    localparam int DATA_SLOT = TAG_SLOT + 1;
    localparam int CRC_SLOT  = DATA_SLOT + DATA_W / 8;
    localparam int SLOT_W    = $clog2(CRC_SLOT + 3);
    localparam logic [SLOT_W-1:0] S_TAG   = SLOT_W'(TAG_SLOT);
    localparam logic [SLOT_W-1:0] S_DATA  = SLOT_W'(DATA_SLOT);
    localparam logic [SLOT_W-1:0] S_CRC   = SLOT_W'(CRC_SLOT);
    localparam logic [SLOT_W-1:0] S_CRCL  = SLOT_W'(CRC_SLOT + 1);
    localparam logic [SLOT_W-1:0] LAST_WR = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] LAST_RD = SLOT_W'(CRC_SLOT - 1);
    localparam logic [SLOT_W-1:0] LAST_RC = SLOT_W'(CRC_SLOT + 1);

    logic              active, rd_q, c16_q, cap_q;
    logic [SLOT_W-1:0] slot, last_slot, doff;
    logic [7:0]        op_q, st_q;
    logic [DATA_W-1:0] data_q;
    logic [15:0]       crc16;

    assign last_slot = !rd_q ? LAST_WR : (c16_q ? LAST_RC : LAST_RD);
    assign resp_last = active && rx_valid && !cs_n && (slot == last_slot);
    assign doff      = slot - S_DATA;

    // CRC-16 over the four data bytes in the order they leave the block.
    always_comb begin
        crc16 = 16'hFFFF;
        for (int k = 0; k < DATA_W / 8; k++)
            crc16 = crc16_byte(crc16, data_q[8*k +: 8]);
    end

    // Select the byte for the next slot from the reply position.
    always_comb begin
        tx_byte = 8'h00;
        if (active) begin
            if (slot == '0)
                tx_byte = op_q;
            else if (slot == SLOT_W'(1))
                tx_byte = st_q;
            else if (rd_q) begin
                if (slot == S_TAG)
                    tx_byte = DATA_TAG;
                else if (slot >= S_DATA && slot < S_CRC)
                    tx_byte = data_q[8*doff[1:0] +: 8];
                else if (slot == S_CRC)
                    tx_byte = crc16[15:8];
                else if (slot == S_CRCL)
                    tx_byte = crc16[7:0];
            end
        end
    end

    // Launch the access, capture read data and step through reply slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slot   <= '0;
            op_q   <= '0;
            st_q   <= '0;
            rd_q   <= 1'b0;
            c16_q  <= 1'b0;
            cap_q  <= 1'b0;
            data_q <= '0;
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
        end else if (cs_n) begin
            active <= 1'b0;
            slot   <= '0;
            cap_q  <= 1'b0;
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
        end else begin
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
            cap_q  <= reg_rd;
            if (cap_q) data_q <= reg_rdata;
            if (frm_done) begin
                active <= 1'b1;
                slot   <= '0;
                op_q   <= frm_op;
                st_q   <= frm_status;
                rd_q   <= (frm_acc == ACC_READ);
                c16_q  <= crc16_en && !frm_clockless && (frm_acc == ACC_READ);
                reg_rd <= (frm_acc == ACC_READ);
                reg_wr <= (frm_acc == ACC_WRITE);
            end else if (active && rx_valid) begin
                if (slot == last_slot) active <= 1'b0;
                else                   slot   <= slot + SLOT_W'(1);
            end
        end
    end

    p_echo_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !cs_n) |=> (cs_n || tx_byte == $past(frm_op)));

    p_rd_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    p_wr_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_abort_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (tx_byte == 8'h00 && !reg_rd && !reg_wr));

endmodule

// File: rtl/spi_cmd_decoder.sv
// Top of the SPI slave command decoder: frame collector feeding the reply
// sequencer, with the register port taken from the decoded frame.
// Assumes: a byte-level shift stage outside this block; see the brief.
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int FILL_BYTES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  tx_byte,
    input  logic        crc7_en,
    input  logic        crc16_en,
    output logic        reg_rd,
    output logic        reg_wr,
    output logic [23:0] reg_addr,
    output logic        reg_internal,
    output logic        reg_clockless,
    output logic [31:0] reg_wdata,
    input  logic [31:0] reg_rdata
);

    logic       frm_done, frm_clockless, resp_last;
    logic [7:0] frm_op, frm_status;
    acc_e       frm_acc;

    spi_cmd_frame u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .crc7_en       (crc7_en),
        .resp_last     (resp_last),
        .frm_done      (frm_done),
        .frm_op        (frm_op),
        .frm_status    (frm_status),
        .frm_acc       (frm_acc),
        .frm_addr      (reg_addr),
        .frm_internal  (reg_internal),
        .frm_clockless (frm_clockless),
        .frm_wdata     (reg_wdata)
    );

    spi_cmd_resp #(.FILL_BYTES(FILL_BYTES)) u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .rx_valid      (rx_valid),
        .crc16_en      (crc16_en),
        .frm_done      (frm_done),
        .frm_op        (frm_op),
        .frm_status    (frm_status),
        .frm_acc       (frm_acc),
        .frm_clockless (frm_clockless),
        .reg_rdata     (reg_rdata),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .resp_last     (resp_last),
        .tx_byte       (tx_byte)
    );

    assign reg_clockless = frm_clockless;

    p_one_kind_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    p_bad_crc_no_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_status == ST_BAD_CRC) |=> (!reg_rd && !reg_wr));

endmodule

// File: tb/spi_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: seeded random access frames plus directed corners.
module spi_cmd_decoder_tb_top;

    localparam int FILL = 2;
    localparam int GAP  = 3;

    logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        crc7_en = 1'b0, crc16_en = 1'b0;
    logic [7:0]  tx_byte;
    logic        reg_rd, reg_wr, reg_internal, reg_clockless;
    logic [23:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = 32'h0;

    always #2.5 clk = ~clk;

    spi_cmd_decoder #(.FILL_BYTES(FILL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_byte), .crc7_en(crc7_en), .crc16_en(crc16_en), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_internal(reg_internal),
        .reg_clockless(reg_clockless), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register model: answers reads one cycle later, records every access.
    logic [31:0] model_val = 32'h0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [23:0] last_addr = '0;
    logic        last_int = 1'b0, last_clk = 1'b0;
    logic [31:0] last_wdata = '0;
    always @(posedge clk) begin
        if (reg_rd) begin
            reg_rdata <= model_val;
            rd_cnt++;
        end
        if (reg_wr) begin
            wr_cnt++;
            last_wdata = reg_wdata;
        end
        if (reg_rd || reg_wr) begin
            last_addr = reg_addr;
            last_int  = reg_internal;
            last_clk  = reg_clockless;
        end
    end

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] fr [0:15];
    logic [7:0] rs [0:15];
    int fl;
    bit quiet;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] tb_crc7(input int n);
        logic [6:0] c = 7'h7F;
        for (int j = 0; j < n; j++)
            for (int i = 7; i >= 0; i--) begin
                logic fb = c[6] ^ fr[j][i];
                c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
            end
        return c;
    endfunction

    function automatic logic [15:0] tb_crc16(input logic [31:0] w);
        logic [15:0] c = 16'hFFFF;
        for (int j = 0; j < 4; j++)
            for (int i = 7; i >= 0; i--) begin
                logic fb = c[15] ^ w[8*j + i];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        return c;
    endfunction

    // One byte slot: drive the byte, capture what the block shifts out.
    task automatic xfer(input logic [7:0] b, output logic [7:0] got);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        got      = tx_byte;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    // Send opcode plus fr[1..nf] (and CRC7), then clock nresp reply bytes.
    task automatic do_frame(input logic [7:0] op, input int nf, input int nresp, input bit corrupt);
        logic [7:0] g;
        fr[0] = op;
        fl = nf + 1;
        if (crc7_en) begin
            fr[fl] = {tb_crc7(fl), 1'b0} ^ (corrupt ? 8'h02 : 8'h00);
            fl++;
        end
        quiet = 1'b1;
        for (int i = 0; i < fl; i++) begin
            xfer(fr[i], g);
            if (g !== 8'h00) quiet = 1'b0;
        end
        for (int i = 0; i < nresp; i++) xfer(8'h00, rs[i]);
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk(req, "tx idle after reply", {24'h0, tx_byte}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int kind, rd0, wr0, nresp;
        logic [31:0] a, d;
        logic cl, isrd, isint;
        logic [23:0] ea;
        logic [15:0] ec;
        logic [7:0] opc;
        string rq;
        void'($urandom(32'h5EED_1234));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "reset tx_byte", {24'h0, tx_byte}, 32'h0);
        chk("R14", "reset reg_rd/reg_wr", {30'h0, reg_rd, reg_wr}, 32'h0);
        cs_n = 1'b0;
        @(negedge clk);

        // Random accesses, back to back on one chip select.
        for (int it = 0; it < 60; it++) begin
            kind     = $urandom_range(0, 3);
            crc7_en  = $urandom_range(0, 1);
            crc16_en = $urandom_range(0, 1);
            model_val = $urandom;
            a  = $urandom;
            d  = $urandom;
            cl = 1'b0;
            rd0 = rd_cnt;
            wr0 = wr_cnt;
            case (kind)
                0: begin
                    opc = 8'hCA; rq = "R2"; isrd = 1; isint = 0;
                    fr[1] = a[23:16]; fr[2] = a[15:8]; fr[3] = a[7:0];
                    ea = a[23:0];
                end
                1: begin
                    opc = 8'hC4; rq = "R3"; isrd = 1; isint = 1; cl = a[31];
                    fr[1] = {cl, a[14:8]}; fr[2] = a[7:0]; fr[3] = 8'h00;
                    ea = {9'd0, a[14:0]};
                end
                2: begin
                    opc = 8'hC9; rq = "R4"; isrd = 0; isint = 0;
                    fr[1] = a[23:16]; fr[2] = a[15:8]; fr[3] = a[7:0];
                    fr[4] = d[31:24]; fr[5] = d[23:16]; fr[6] = d[15:8]; fr[7] = d[7:0];
                    ea = a[23:0];
                end
                default: begin
                    opc = 8'hC3; rq = "R5"; isrd = 0; isint = 1; cl = a[31];
                    fr[1] = {cl, a[14:8]}; fr[2] = a[7:0];
                    fr[3] = d[31:24]; fr[4] = d[23:16]; fr[5] = d[15:8]; fr[6] = d[7:0];
                    ea = {9'd0, a[14:0]};
                end
            endcase
            nresp = isrd ? (7 + FILL + ((crc16_en && !cl) ? 2 : 0)) : 2;
            do_frame(opc, (kind == 2) ? 7 : (kind == 3) ? 6 : 3, nresp, 1'b0);
            chk("R13", "tx zero while receiving", {31'h0, quiet}, 32'h1);
            chk("R1", "echo in first reply slot", {24'h0, rs[0]}, {24'h0, opc});
            chk("R6", "status ok", {24'h0, rs[1]}, 32'h0);
            chk("R14", "read count delta", rd_cnt - rd0, isrd ? 1 : 0);
            chk("R14", "write count delta", wr_cnt - wr0, isrd ? 0 : 1);
            chk(rq, "address", {8'h0, last_addr}, {8'h0, ea});
            chk(rq, "internal/clockless", {30'h0, last_int, last_clk}, {30'h0, isint, cl});
            if (isrd) begin
                for (int f = 0; f < FILL; f++)
                    chk("R7", "filler byte", {24'h0, rs[2 + f]}, 32'h0);
                chk("R7", "data tag", {24'h0, rs[2 + FILL]}, 32'hF3);
                chk("R7", "data LSB first",
                    {rs[6 + FILL], rs[5 + FILL], rs[4 + FILL], rs[3 + FILL]}, model_val);
                if (crc16_en && !cl) begin
                    ec = tb_crc16(model_val);
                    chk("R8", "crc16", {16'h0, rs[7 + FILL], rs[8 + FILL]}, {16'h0, ec});
                end
            end else begin
                chk(rq, "write data", last_wdata, d);
            end
            idle_check("R13");
        end

        // Corrupted CRC7 on a single read: error status, no access.
        crc7_en = 1'b1; crc16_en = 1'b1;
        rd0 = rd_cnt; wr0 = wr_cnt;
        fr[1] = 8'h12; fr[2] = 8'h34; fr[3] = 8'h56;
        do_frame(8'hCA, 3, 2, 1'b1);
        chk("R9", "bad crc7 status", {24'h0, rs[1]}, 32'h2);
        chk("R9", "bad crc7 no access", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
        idle_check("R9");

        // Unknown opcode with a correct CRC7: opcode error wins.
        rd0 = rd_cnt; wr0 = wr_cnt;
        fr[1] = 8'hAA; fr[2] = 8'hBB; fr[3] = 8'hCC;
        do_frame(8'h55, 3, 2, 1'b0);
        chk("R10", "unknown op echo", {24'h0, rs[0]}, 32'h55);
        chk("R10", "unknown op status", {24'h0, rs[1]}, 32'h1);
        chk("R10", "unknown op no access", (rd_cnt - rd0) + (wr_cnt - wr0), 0);

        // Acknowledged opcodes with no register access.
        crc7_en = 1'b0;
        rd0 = rd_cnt; wr0 = wr_cnt;
        for (int i = 1; i <= 6; i++) fr[i] = 8'(i * 17);
        do_frame(8'hC7, 6, 2, 1'b0);
        chk("R11", "ext dma echo", {24'h0, rs[0]}, 32'hC7);
        chk("R11", "ext dma status", {24'h0, rs[1]}, 32'h0);
        do_frame(8'hC2, 5, 2, 1'b0);
        chk("R11", "dma read echo", {24'h0, rs[0]}, 32'hC2);
        do_frame(8'hCF, 3, 2, 1'b0);
        chk("R11", "reset status", {24'h0, rs[1]}, 32'h0);
        chk("R11", "no access", (rd_cnt - rd0) + (wr_cnt - wr0), 0);

        // Chip select abort in the middle of a write frame.
        wr0 = wr_cnt;
        begin
            logic [7:0] g;
            xfer(8'hC9, g);
            xfer(8'h01, g);
            xfer(8'h02, g);
            xfer(8'h03, g);
        end
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", "tx during abort", {24'h0, tx_byte}, 32'h0);
        cs_n = 1'b0;
        @(negedge clk);
        chk("R12", "aborted frame no write", wr_cnt - wr0, 0);
        fr[1] = 8'h0A; fr[2] = 8'h0B; fr[3] = 8'h0C;
        fr[4] = 8'hDE; fr[5] = 8'hAD; fr[6] = 8'hBE; fr[7] = 8'hEF;
        do_frame(8'hC9, 7, 2, 1'b0);
        chk("R12", "frame after abort writes", wr_cnt - wr0, 1);
        chk("R12", "frame after abort addr", {8'h0, last_addr}, 32'h000A0B0C);
        chk("R12", "frame after abort data", last_wdata, 32'hDEADBEEF);

        // Clockless internal read with CRC16 on: no CRC bytes appended.
        crc16_en = 1'b1;
        model_val = 32'h89AB_CDEF;
        fr[1] = 8'h81; fr[2] = 8'h22; fr[3] = 8'h00;
        do_frame(8'hC4, 3, 7 + FILL, 1'b0);
        chk("R8", "clockless data", {rs[6 + FILL], rs[5 + FILL], rs[4 + FILL], rs[3 + FILL]}, 32'h89AB_CDEF);
        idle_check("R8");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule